// File: doc/BRIEF.md
# Timed Multi-Channel Output Write Buffer

This block stages output words for a group of N channels. A single write request carries one word for every channel. The words are placed in a one-entry staging slot per lane. From there each word moves into a per-lane holding register. An external sample pulse then copies the holding register onto that lane's output pins.

A write is accepted for all lanes or for none. It never replaces a staged word that has not yet moved on. If the slots are occupied, the request can wait for a programmable number of clock ticks, or wait indefinitely. If the wait runs out, the request is dropped and a one-cycle timed-out flag is raised.

A registered ready output throttles the producer. A request presented in the cycle after ready was low is ignored. A completion flag reports when the words of the most recent accepted write have all left the staging slots. If a sample pulse arrives when no new word is waiting, the lane drives its last value again.

Top module: `chan_write_buffer`

## Requirements
- R1: After a synchronous active-low reset, `wr_ready` is 1, `timed_out` is 0, `write_done` is 0 and every lane of `chan_out` is 0.
- R2: A request (`wr_valid` high in a cycle whose preceding cycle had `wr_ready` high) that finds every staging slot empty is written into all lanes at the next clock edge. Lane k's word is `wr_data[k*W +: W]` and appears on `chan_out[k*W +: W]`.
- R3: A write never replaces a staged word that has not yet moved to its holding register.
- R4: With `wait_ticks` = 0, a request that finds any slot occupied is dropped, and `timed_out` is high for one cycle in the cycle after the request.
- R5: With `wait_ticks` = T > 0, a blocked request is retried on each of the next T cycles. It is written as soon as all slots are free. Otherwise `timed_out` is high in cycle request+T+1.
- R6: With a negative `wait_ticks` (-1), a blocked request waits without limit and is written once all slots become free.
- R7: A request that times out writes no lane. Staged words, held words and pins keep their values, and later pulses drive out only earlier data.
- R8: A staged word moves to its holding register on the next edge if the holding register is free. Otherwise it moves at the edge of the next sample pulse, while the pulse drives the older held word onto the pins.
- R9: A sample pulse with no new held word re-drives the last word, so `chan_out` keeps that value. Without a pulse, `chan_out` never changes.
- R10: A request presented in the cycle right after a cycle with `wr_ready` low is discarded, even though `wr_valid` is high.
- R11: `wr_ready` is registered. It is low in the cycle after any cycle in which a staging slot was occupied or a request was waiting.
- R12: `write_done` goes high in the cycle after the last accepted write's words have all left the staging slots. It stays high until the next write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Registered ready for a request in the following cycle |
| wr_data | input | N*W | One word per lane, lane 0 in the low bits |
| wait_ticks | input | TW | Signed wait limit in clock ticks; 0 = none, negative = unlimited |
| timed_out | output | 1 | One-cycle flag: the request was dropped |
| sample_pulse | input | 1 | Drives held words onto the lane outputs |
| chan_out | output | N*W | Lane output pins, lane 0 in the low bits |
| write_done | output | 1 | Last accepted write has fully left staging |

## Verification
Each stimulus is applied between clock edges, and every result is due at a fixed number of edges after it. A write fills staging one edge after the request. The word reaches the holding register one edge later if that register is free. `write_done` rises one edge after that. `chan_out` changes one edge after a sample pulse. `wr_ready` follows slot occupancy with one edge of lag. `timed_out` rises one edge after a zero-limit request, or T+1 edges after a waiting one. The bench walks a cycle table and samples mid-cycle after each edge, so every expected value sits at the exact cycle these counts give.

// File: rtl/cwb_pkg.sv
// Shared types for the channel write buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package cwb_pkg;
    // Request controller state: idle, or holding a blocked request.
    typedef enum logic {
        CWB_IDLE = 1'b0,
        CWB_WAIT = 1'b1
    } cwb_state_e;
endpackage

// File: rtl/cwb_lane.sv
// One output lane: a one-entry staging slot, a holding register and
// the pin register loaded by the sample pulse.
// Assumes: wr_en is only raised while stg_valid is low (caller's duty).
module cwb_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_word,
    input  logic         pulse,
    output logic         stg_valid,
    output logic [W-1:0] pin_word
);
    logic [W-1:0] stg_word;
    logic [W-1:0] held_word;
    logic         held_new;
    logic         move;

    // Staged word advances when the holding register is free or being emptied.
    assign move = stg_valid && (!held_new || pulse);

    // Staging slot: filled by a write, emptied by a move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_valid <= 1'b0;
            stg_word  <= '0;
        end else if (wr_en) begin
            stg_valid <= 1'b1;
            stg_word  <= wr_word;
        end else if (move) begin
            stg_valid <= 1'b0;
        end
    end

    // Holding register: takes moved words; "new" until a pulse drives it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_word <= '0;
            held_new  <= 1'b0;
        end else if (move) begin
            held_word <= stg_word;
            held_new  <= 1'b1;
        end else if (pulse) begin
            held_new  <= 1'b0;
        end
    end

    // Pin register: every pulse drives the held word (re-drive when not new).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_word <= '0;
        end else if (pulse) begin
            pin_word <= held_word;
        end
    end
endmodule

// File: rtl/cwb_ctrl.sv
// Request controller: handshake gating, all-or-nothing write decision,
// tick-limited wait, timed-out flag, ready and completion flags.
// Assumes: all_free/any_busy come from the lanes' staging slots.
module cwb_ctrl
    import cwb_pkg::*;
#(
    parameter int DW = 32,
    parameter int TW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [DW-1:0]        req_data,
    input  logic signed [TW-1:0] req_ticks,
    input  logic                 all_free,
    input  logic                 any_busy,
    output logic                 req_take,
    output logic                 wr_fire,
    output logic [DW-1:0]        wr_bus,
    output logic                 ready_q,
    output logic                 tmo_q,
    output logic                 done_q
);
    cwb_state_e    state;
    logic          ready_d1;
    logic [DW-1:0] held_data;
    logic [TW-1:0] ticks_left;
    logic          no_limit;
    logic          pending;

    // A request counts only if ready was high in the previous cycle.
    assign req_take = req_valid && ready_d1 && (state == CWB_IDLE);
    // Write all lanes when every slot is free, from a new or a waiting request.
    assign wr_fire  = all_free && (req_take || (state == CWB_WAIT));
    assign wr_bus   = (state == CWB_WAIT) ? held_data : req_data;

    // Wait state machine, tick counter and timed-out flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= CWB_IDLE;
            held_data  <= '0;
            ticks_left <= '0;
            no_limit   <= 1'b0;
            tmo_q      <= 1'b0;
        end else begin
            tmo_q <= 1'b0;
            if (state == CWB_IDLE) begin
                if (req_take && !all_free) begin
                    if (req_ticks == '0) begin
                        tmo_q <= 1'b1;
                    end else begin
                        state      <= CWB_WAIT;
                        held_data  <= req_data;
                        ticks_left <= $unsigned(req_ticks);
                        no_limit   <= (req_ticks < 0);
                    end
                end
            end else begin
                if (all_free) begin
                    state <= CWB_IDLE;
                end else if (!no_limit) begin
                    if (ticks_left == TW'(1)) begin
                        tmo_q <= 1'b1;
                        state <= CWB_IDLE;
                    end else begin
                        ticks_left <= ticks_left - TW'(1);
                    end
                end
            end
        end
    end

    // Registered ready and its one-cycle delayed copy used for gating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q  <= 1'b1;
            ready_d1 <= 1'b1;
        end else begin
            ready_q  <= !(any_busy || (state == CWB_WAIT));
            ready_d1 <= ready_q;
        end
    end

    // Completion flag for the last accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            done_q  <= 1'b0;
        end else if (wr_fire) begin
            pending <= 1'b1;
            done_q  <= 1'b0;
        end else if (pending && all_free) begin
            pending <= 1'b0;
            done_q  <= 1'b1;
        end
    end
endmodule

// File: rtl/chan_write_buffer.sv
// Top: N lanes of staged output with one shared request controller.
// Assumes: lane 0 occupies the low W bits of wr_data and chan_out.
module chan_write_buffer #(
    parameter int N  = 4,
    parameter int W  = 8,
    parameter int TW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    output logic                 wr_ready,
    input  logic [N*W-1:0]       wr_data,
    input  logic signed [TW-1:0] wait_ticks,
    output logic                 timed_out,
    input  logic                 sample_pulse,
    output logic [N*W-1:0]       chan_out,
    output logic                 write_done
);
    localparam int DW = N * W;

    logic [N-1:0]  slot_busy;
    logic          all_free;
    logic          any_busy;
    logic          req_take;
    logic          wr_fire;
    logic [DW-1:0] wr_bus;

    assign all_free = ~|slot_busy;
    assign any_busy = |slot_busy;

    cwb_ctrl #(.DW(DW), .TW(TW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (wr_valid),
        .req_data  (wr_data),
        .req_ticks (wait_ticks),
        .all_free  (all_free),
        .any_busy  (any_busy),
        .req_take  (req_take),
        .wr_fire   (wr_fire),
        .wr_bus    (wr_bus),
        .ready_q   (wr_ready),
        .tmo_q     (timed_out),
        .done_q    (write_done)
    );

    for (genvar k = 0; k < N; k++) begin : g_lane
        cwb_lane #(.W(W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_fire),
            .wr_word   (wr_bus[k*W +: W]),
            .pulse     (sample_pulse),
            .stg_valid (slot_busy[k]),
            .pin_word  (chan_out[k*W +: W])
        );
    end
endmodule

// File: rtl/cwb_checker.sv
// Property checker for chan_write_buffer, attached by bind.
// Assumes: reset is held low for at least one edge at start-up.
module cwb_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_ready,
    input logic          timed_out,
    input logic          write_done,
    input logic          sample_pulse,
    input logic [DW-1:0] chan_out,
    input logic          any_busy,
    input logic          wr_fire,
    input logic          req_take
);
    // R1: first cycle out of reset shows the reset values.
    p_reset_values_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (wr_ready && !timed_out && !write_done && chan_out == '0));

    // R3: no write while any staging slot is occupied.
    p_no_overwrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        any_busy |-> !wr_fire);

    // R9: pins only change after a sample pulse.
    p_pins_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_pulse |=> $stable(chan_out));

    // R10: ready low means no request is taken next cycle.
    p_discard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |=> !req_take);

    // R11: an occupied slot forces ready low next cycle.
    p_ready_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        any_busy |=> !wr_ready);

    // R12: completion is never reported while staging holds data.
    p_done_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
        write_done |-> !any_busy);
endmodule

bind chan_write_buffer cwb_checker #(.DW(N*W)) u_cwb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ready     (wr_ready),
    .timed_out    (timed_out),
    .write_done   (write_done),
    .sample_pulse (sample_pulse),
    .chan_out     (chan_out),
    .any_busy     (any_busy),
    .wr_fire      (wr_fire),
    .req_take     (req_take)
);

// File: tb/chan_write_buffer_test.sv
// Cycle-table bench for chan_write_buffer with two 8-bit lanes.
module chan_write_buffer_test;
    localparam int N  = 2;
    localparam int W  = 8;
    localparam int TW = 16;
    localparam int NV = 32;

    localparam logic [15:0] D1 = 16'h2211, D2 = 16'h4433, D3 = 16'h6655;
    localparam logic [15:0] D4 = 16'h8877, D5 = 16'hAA99, D6 = 16'hCCBB;
    localparam logic [15:0] D7 = 16'hEEDD, Z = 16'h0000;
    localparam logic [15:0] T0 = 16'd0, T2 = 16'd2, TF = 16'hFFFF;

    // {valid, pulse, ticks, data, exp_ready, exp_tmo, exp_done, exp_pins, req}
    localparam logic [56:0] VEC [NV] = '{
        {1'b1,1'b0,T0,D1, 1'b1,1'b0,1'b0,Z,  4'd2},  // R2 write to empty slots
        {1'b1,1'b0,T0,D2, 1'b0,1'b1,1'b0,Z,  4'd4},  // R4 blocked, zero limit
        {1'b0,1'b0,T0,Z,  1'b1,1'b0,1'b1,Z,  4'd12}, // R12 done after move
        {1'b1,1'b0,T0,D2, 1'b1,1'b0,1'b1,Z,  4'd10}, // R10 discarded
        {1'b0,1'b1,T0,Z,  1'b1,1'b0,1'b1,D1, 4'd2},  // R2 pulse drives D1
        {1'b1,1'b0,T0,D2, 1'b1,1'b0,1'b0,D1, 4'd2},  // R2 write D2
        {1'b1,1'b0,T2,D3, 1'b0,1'b0,1'b0,D1, 4'd11}, // R11 wait entered
        {1'b0,1'b0,T0,Z,  1'b0,1'b0,1'b0,D1, 4'd5},  // R5 written in wait
        {1'b1,1'b0,T2,D4, 1'b0,1'b0,1'b0,D1, 4'd10}, // R10 discarded
        {1'b0,1'b1,T0,Z,  1'b0,1'b0,1'b0,D2, 4'd8},  // R8 move at pulse
        {1'b0,1'b0,T0,Z,  1'b1,1'b0,1'b1,D2, 4'd12}, // R12 done
        {1'b1,1'b0,T2,D4, 1'b1,1'b0,1'b1,D2, 4'd10}, // R10 discarded
        {1'b1,1'b0,T2,D4, 1'b1,1'b0,1'b0,D2, 4'd2},  // R2 write D4
        {1'b1,1'b0,T2,D5, 1'b0,1'b0,1'b0,D2, 4'd3},  // R3 D5 blocked
        {1'b0,1'b0,T0,Z,  1'b0,1'b0,1'b0,D2, 4'd5},  // R5 still waiting
        {1'b0,1'b0,T0,Z,  1'b0,1'b1,1'b0,D2, 4'd5},  // R5 timeout at T+1
        {1'b0,1'b1,T0,Z,  1'b0,1'b0,1'b0,D3, 4'd7},  // R7 old data kept
        {1'b0,1'b1,T0,Z,  1'b1,1'b0,1'b1,D4, 4'd7},  // R7 D4 not D5
        {1'b0,1'b1,T0,Z,  1'b1,1'b0,1'b1,D4, 4'd9},  // R9 re-drive
        {1'b1,1'b0,TF,D5, 1'b1,1'b0,1'b0,D4, 4'd2},  // R2 write D5
        {1'b0,1'b0,T0,Z,  1'b0,1'b0,1'b0,D4, 4'd8},  // R8 immediate move
        {1'b0,1'b0,T0,Z,  1'b1,1'b0,1'b1,D4, 4'd12}, // R12
        {1'b0,1'b0,T0,Z,  1'b1,1'b0,1'b1,D4, 4'd12}, // R12 stays high
        {1'b1,1'b0,TF,D6, 1'b1,1'b0,1'b0,D4, 4'd2},  // R2 write D6
        {1'b1,1'b0,TF,D7, 1'b0,1'b0,1'b0,D4, 4'd6},  // R6 unlimited wait
        {1'b0,1'b0,T0,Z,  1'b0,1'b0,1'b0,D4, 4'd6},  // R6
        {1'b0,1'b0,T0,Z,  1'b0,1'b0,1'b0,D4, 4'd6},  // R6
        {1'b0,1'b0,T0,Z,  1'b0,1'b0,1'b0,D4, 4'd6},  // R6
        {1'b0,1'b1,T0,Z,  1'b0,1'b0,1'b0,D5, 4'd8},  // R8
        {1'b0,1'b0,T0,Z,  1'b0,1'b0,1'b0,D5, 4'd6},  // R6 D7 written
        {1'b0,1'b1,T0,Z,  1'b0,1'b0,1'b0,D6, 4'd8},  // R8
        {1'b0,1'b1,T0,Z,  1'b1,1'b0,1'b1,D7, 4'd6}   // R6 D7 out
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 wr_valid = 1'b0;
    logic                 wr_ready;
    logic [N*W-1:0]       wr_data = '0;
    logic signed [TW-1:0] wait_ticks = '0;
    logic                 timed_out;
    logic                 sample_pulse = 1'b0;
    logic [N*W-1:0]       chan_out;
    logic                 write_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    chan_write_buffer #(.N(N), .W(W), .TW(TW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_valid     (wr_valid),
        .wr_ready     (wr_ready),
        .wr_data      (wr_data),
        .wait_ticks   (wait_ticks),
        .timed_out    (timed_out),
        .sample_pulse (sample_pulse),
        .chan_out     (chan_out),
        .write_done   (write_done)
    );

    task automatic check_outs(input int req, input logic er, input logic et,
                              input logic ed, input logic [15:0] ep);
        checks++;
        if (wr_ready !== er || timed_out !== et || write_done !== ed || chan_out !== ep) begin
            fails++;
            $display("FAIL R%0d: got rdy=%b tmo=%b done=%b out=%h, expected rdy=%b tmo=%b done=%b out=%h",
                     req, wr_ready, timed_out, write_done, chan_out, er, et, ed, ep);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_outs(1, 1'b1, 1'b0, 1'b0, Z);  // R1 reset state

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_valid     = VEC[i][56];
            sample_pulse = VEC[i][55];
            wait_ticks   = VEC[i][54:39];
            wr_data      = VEC[i][38:23];
            @(posedge clk);
            #5;
            check_outs(int'(VEC[i][3:0]), VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19:4]);
        end

        // R1: reset in mid-run clears pins and flags.
        @(negedge clk);
        wr_valid = 1'b0;
        sample_pulse = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #5;
        check_outs(1, 1'b1, 1'b0, 1'b0, Z);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: pulses with nothing staged keep the pins at zero.
        @(negedge clk);
        sample_pulse = 1'b1;
        @(posedge clk);
        #5;
        check_outs(9, 1'b1, 1'b0, 1'b0, Z);
        @(negedge clk);
        sample_pulse = 1'b0;

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got no end of test, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule